// File: doc/BRIEF.md
# Serial Gain Register Port for a Two-Channel Attenuator

This block is the control front end of a stereo volume controller. A host talks to it over a three-wire serial link: an active-low select, a serial clock and one data line whose pad is driven through separate in, out and enable signals. Each transaction is exactly sixteen clocks long. The first byte names a register and says whether the host reads or writes. The second byte is either the value to store or the value the block sends back. The serial lines are brought into the system clock domain through synchronisers, and all edges are found there.

The block keeps three registers: left gain, right gain and the overload threshold. It also keeps a two-bit overload status that the peak detectors set and that a completed read clears. A separate write-only address loads one value into both gains at once. Each accepted gain write raises a one-cycle update strobe for that channel. The downstream gain-change logic uses this strobe to start its wait for a zero crossing.

Top module: `vol_serial_port`

## Requirements
- R1: The data line is sampled on rising serial clock edges while select is low, most significant bit first. A frame is an address byte followed by a data byte. Address bits [6:3] select the register, bit 2 is the direction (1 = read, 0 = write), and bits 7, 1 and 0 are ignored. Each serial clock level lasts at least 6 system clocks.
- R2: A complete write with selector 4'b1110 loads the right gain, and one with selector 4'b1101 loads the left gain. A read of either returns the stored value.
- R3: Selector 4'b1001 is write-only. A complete write loads its data byte into both gains, and a read of it returns 8'h00.
- R4: Selector 4'b1100 is the threshold register. It can be read and written.
- R5: After reset both gains read 8'h00, the status reads 8'h00 and the threshold reads 8'hFF.
- R6: During the data byte of a read, the block drives the data line, changing it after falling serial clock edges. At all other times the output enable is low, and always while select is high.
- R7: A frame with fewer or more than sixteen rising clocks before select rises changes no register and raises no strobe.
- R8: Selector 4'b1011 reads the status byte: bit 1 is left overload, bit 0 is right overload, and the upper bits are zero. A bit stays set after a detector pulse until a complete status read, which clears the bits it reported. Writes to this selector are ignored.
- R9: Every accepted write to a gain raises that channel's update strobe for exactly one cycle, in the same cycle the gain output takes its new value. A gain output never changes without its strobe.
- R10: Writes to any other selector are ignored, and reads of them return 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csn_i | input | 1 | Serial select, active low, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| sdio_i | input | 1 | Serial data from the pad |
| sdio_o | output | 1 | Serial data to the pad |
| sdio_oe_o | output | 1 | Pad output enable (0 = high impedance) |
| ovl_left_i | input | 1 | Left peak detector overload pulse |
| ovl_right_i | input | 1 | Right peak detector overload pulse |
| gain_left_o | output | 8 | Left gain code |
| gain_right_o | output | 8 | Right gain code |
| thresh_o | output | 8 | Overload threshold code |
| upd_left_o | output | 1 | One-cycle left gain update strobe |
| upd_right_o | output | 1 | One-cycle right gain update strobe |

## Verification
The assertions check several rules on every cycle. Each update strobe is a single-cycle pulse, and a gain output holds its value unless its strobe is high. The port values right after reset are the reset values. The output enable is low once select has been high for a few cycles. The bench scenarios cover what depends on a whole frame: the selector decode, the alias write, reads that return the right bytes, the discarding of short and over-long frames, and the sticky status bits with clear-on-read.

// File: rtl/volp_pkg.sv
package volp_pkg;

    localparam int BYTE_W     = 8;
    localparam int FRAME_BITS = 2 * BYTE_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);
    localparam int SEL_W      = 4;

    localparam logic [SEL_W-1:0] SEL_RIGHT  = 4'b1110;
    localparam logic [SEL_W-1:0] SEL_LEFT   = 4'b1101;
    localparam logic [SEL_W-1:0] SEL_THRESH = 4'b1100;
    localparam logic [SEL_W-1:0] SEL_STATUS = 4'b1011;
    localparam logic [SEL_W-1:0] SEL_BOTH   = 4'b1001;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic              rd;
        logic [BYTE_W-1:0] data;
    } frame_t;

    // Which gain channels a write selector targets: {left, right}
    function automatic logic [1:0] gain_targets(logic [SEL_W-1:0] sel);
        logic [1:0] hit;
        case (sel)
            SEL_LEFT:  hit = 2'b10;
            SEL_RIGHT: hit = 2'b01;
            SEL_BOTH:  hit = 2'b11;
            default:   hit = 2'b00;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/volp_sync.sv
module volp_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= RST_VAL;
                    else     stg[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stg[STAGES-1];

endmodule

// File: rtl/volp_frame.sv
module volp_frame
    import volp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              csn_s,
    input  logic              sck_s,
    input  logic              sdi_s,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              hdr_valid_o,
    output logic [SEL_W-1:0]  hdr_sel_o,
    output logic              hdr_rd_o,
    output logic              commit_wr_o,
    output logic              commit_rd_o,
    output frame_t            frame_o,
    output logic              sdo_o,
    output logic              sdo_oe_o
);

    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

    logic              sck_prev_q;
    logic              sck_rise, sck_fall;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] tx_q;
    logic [SEL_W-1:0]  sel_q;
    logic              rd_q;
    logic              hdr_valid_q;
    logic              commit_wr_q, commit_rd_q;
    logic              sdo_q, oe_q;
    logic              in_data_phase;

    assign sck_rise      = sck_s & ~sck_prev_q;
    assign sck_fall      = ~sck_s & sck_prev_q;
    assign in_data_phase = (cnt_q >= CNT_DATA) && (cnt_q < CNT_FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev_q  <= 1'b0;
            cnt_q       <= '0;
            sh_q        <= '0;
            tx_q        <= '0;
            sel_q       <= '0;
            rd_q        <= 1'b0;
            hdr_valid_q <= 1'b0;
            commit_wr_q <= 1'b0;
            commit_rd_q <= 1'b0;
            sdo_q       <= 1'b0;
            oe_q        <= 1'b0;
        end else begin
            sck_prev_q  <= sck_s;
            hdr_valid_q <= 1'b0;
            commit_wr_q <= 1'b0;
            commit_rd_q <= 1'b0;

            if (hdr_valid_q && rd_q) begin
                tx_q <= rd_data_i;
            end

            if (csn_s) begin
                // End of frame: only an exact sixteen-bit frame is acted on
                if (cnt_q == CNT_FULL) begin
                    commit_wr_q <= ~rd_q;
                    commit_rd_q <= rd_q;
                end
                cnt_q <= '0;
                oe_q  <= 1'b0;
            end else begin
                if (sck_rise && (cnt_q != CNT_OVER)) begin
                    sh_q  <= {sh_q[BYTE_W-2:0], sdi_s};
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CNT_HDR) begin
                        sel_q       <= sh_q[5:2];
                        rd_q        <= sh_q[1];
                        hdr_valid_q <= 1'b1;
                    end
                end
                if (sck_fall && rd_q && in_data_phase) begin
                    sdo_q <= tx_q[BYTE_W-1];
                    tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                    oe_q  <= 1'b1;
                end
            end
        end
    end

    assign hdr_valid_o  = hdr_valid_q;
    assign hdr_sel_o    = sel_q;
    assign hdr_rd_o     = rd_q;
    assign commit_wr_o  = commit_wr_q;
    assign commit_rd_o  = commit_rd_q;
    assign frame_o.sel  = sel_q;
    assign frame_o.rd   = rd_q;
    assign frame_o.data = sh_q;
    assign sdo_o        = sdo_q;
    assign sdo_oe_o     = oe_q;

endmodule

// File: rtl/volp_regs.sv
module volp_regs
    import volp_pkg::*;
#(
    parameter logic [BYTE_W-1:0] GAIN_RST   = 8'h00,
    parameter logic [BYTE_W-1:0] THRESH_RST = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hdr_valid_i,
    input  logic [SEL_W-1:0]  hdr_sel_i,
    input  logic              hdr_rd_i,
    input  logic              commit_wr_i,
    input  logic              commit_rd_i,
    input  frame_t            frame_i,
    input  logic              ovl_left_i,
    input  logic              ovl_right_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic [BYTE_W-1:0] gain_left_o,
    output logic [BYTE_W-1:0] gain_right_o,
    output logic [BYTE_W-1:0] thresh_o,
    output logic              upd_left_o,
    output logic              upd_right_o
);

    logic [BYTE_W-1:0] gain_l_q, gain_r_q, thresh_q;
    logic [1:0]        stat_q, snap_q, stat_clr;
    logic              upd_l_q, upd_r_q;
    logic [1:0]        hit;

    assign hit = commit_wr_i ? gain_targets(frame_i.sel) : 2'b00;

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_l_q <= GAIN_RST;
            gain_r_q <= GAIN_RST;
            thresh_q <= THRESH_RST;
            upd_l_q  <= 1'b0;
            upd_r_q  <= 1'b0;
        end else begin
            upd_l_q <= hit[1];
            upd_r_q <= hit[0];
            if (hit[1]) gain_l_q <= frame_i.data;
            if (hit[0]) gain_r_q <= frame_i.data;
            if (commit_wr_i && (frame_i.sel == SEL_THRESH)) thresh_q <= frame_i.data;
        end
    end

    // Sticky overload flags; a finished status read clears what it reported
    assign stat_clr = (commit_rd_i && (frame_i.sel == SEL_STATUS)) ? snap_q : 2'b00;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= 2'b00;
            snap_q <= 2'b00;
        end else begin
            stat_q <= (stat_q & ~stat_clr) | {ovl_left_i, ovl_right_i};
            if (hdr_valid_i && hdr_rd_i && (hdr_sel_i == SEL_STATUS)) snap_q <= stat_q;
        end
    end

    always_comb begin
        case (hdr_sel_i)
            SEL_RIGHT:  rd_data_o = gain_r_q;
            SEL_LEFT:   rd_data_o = gain_l_q;
            SEL_THRESH: rd_data_o = thresh_q;
            SEL_STATUS: rd_data_o = {{(BYTE_W-2){1'b0}}, stat_q};
            default:    rd_data_o = '0;
        endcase
    end

    assign gain_left_o  = gain_l_q;
    assign gain_right_o = gain_r_q;
    assign thresh_o     = thresh_q;
    assign upd_left_o   = upd_l_q;
    assign upd_right_o  = upd_r_q;

endmodule

// File: rtl/vol_serial_port.sv
module vol_serial_port
    import volp_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] GAIN_RST    = 8'h00,
    parameter logic [BYTE_W-1:0] THRESH_RST  = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csn_i,
    input  logic              sck_i,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe_o,
    input  logic              ovl_left_i,
    input  logic              ovl_right_i,
    output logic [BYTE_W-1:0] gain_left_o,
    output logic [BYTE_W-1:0] gain_right_o,
    output logic [BYTE_W-1:0] thresh_o,
    output logic              upd_left_o,
    output logic              upd_right_o
);

    logic [2:0]        line_s;
    logic              hdr_valid, hdr_rd, commit_wr, commit_rd;
    logic [SEL_W-1:0]  hdr_sel;
    logic [BYTE_W-1:0] rd_data;
    frame_t            frame;

    // line order: {select, clock, data}; select idles high
    volp_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({csn_i, sck_i, sdio_i}),
        .sync_o  (line_s)
    );

    volp_frame u_frame (
        .clk         (clk),
        .rst         (rst),
        .csn_s       (line_s[2]),
        .sck_s       (line_s[1]),
        .sdi_s       (line_s[0]),
        .rd_data_i   (rd_data),
        .hdr_valid_o (hdr_valid),
        .hdr_sel_o   (hdr_sel),
        .hdr_rd_o    (hdr_rd),
        .commit_wr_o (commit_wr),
        .commit_rd_o (commit_rd),
        .frame_o     (frame),
        .sdo_o       (sdio_o),
        .sdo_oe_o    (sdio_oe_o)
    );

    volp_regs #(
        .GAIN_RST   (GAIN_RST),
        .THRESH_RST (THRESH_RST)
    ) u_regs (
        .clk          (clk),
        .rst          (rst),
        .hdr_valid_i  (hdr_valid),
        .hdr_sel_i    (hdr_sel),
        .hdr_rd_i     (hdr_rd),
        .commit_wr_i  (commit_wr),
        .commit_rd_i  (commit_rd),
        .frame_i      (frame),
        .ovl_left_i   (ovl_left_i),
        .ovl_right_i  (ovl_right_i),
        .rd_data_o    (rd_data),
        .gain_left_o  (gain_left_o),
        .gain_right_o (gain_right_o),
        .thresh_o     (thresh_o),
        .upd_left_o   (upd_left_o),
        .upd_right_o  (upd_right_o)
    );

endmodule

// File: rtl/volp_checker.sv
module volp_checker (
    input logic       clk,
    input logic       rst,
    input logic       csn_i,
    input logic       sdio_oe_o,
    input logic [7:0] gain_left_o,
    input logic [7:0] gain_right_o,
    input logic [7:0] thresh_o,
    input logic       upd_left_o,
    input logic       upd_right_o
);

    p_upd_left_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        upd_left_o |=> !upd_left_o);

    p_upd_right_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        upd_right_o |=> !upd_right_o);

    p_gain_left_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !upd_left_o |-> $stable(gain_left_o));

    p_gain_right_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !upd_right_o |-> $stable(gain_right_o));

    p_reset_values_r5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (gain_left_o == 8'h00 && gain_right_o == 8'h00 && thresh_o == 8'hFF));

    p_hiz_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (csn_i && $past(csn_i) && $past(csn_i, 2) && $past(csn_i, 3) && $past(csn_i, 4))
            |-> !sdio_oe_o);

endmodule

bind vol_serial_port volp_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .csn_i        (csn_i),
    .sdio_oe_o    (sdio_oe_o),
    .gain_left_o  (gain_left_o),
    .gain_right_o (gain_right_o),
    .thresh_o     (thresh_o),
    .upd_left_o   (upd_left_o),
    .upd_right_o  (upd_right_o)
);

// File: tb/vol_serial_port_tb.sv
module vol_serial_port_tb;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       csn = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic       ovl_l = 1'b0, ovl_r = 1'b0;
    logic       sdo, sdo_oe, upd_l, upd_r;
    logic [7:0] g_l, g_r, thr;

    int vectors = 0, errors = 0, n_upd_l = 0, n_upd_r = 0;
    bit done = 0;

    // model state
    logic [7:0] m_l = 8'h00, m_r = 8'h00, m_t = 8'hFF;
    logic [1:0] m_st = 2'b00;
    int         e_upd_l = 0, e_upd_r = 0;

    always #10 clk = ~clk;

    vol_serial_port u_dut (
        .clk(clk), .rst(rst), .csn_i(csn), .sck_i(sck), .sdio_i(sdi),
        .sdio_o(sdo), .sdio_oe_o(sdo_oe), .ovl_left_i(ovl_l), .ovl_right_i(ovl_r),
        .gain_left_o(g_l), .gain_right_o(g_r), .thresh_o(thr),
        .upd_left_o(upd_l), .upd_right_o(upd_r)
    );

    always @(posedge clk) begin
        if (upd_l) n_upd_l <= n_upd_l + 1;
        if (upd_r) n_upd_r <= n_upd_r + 1;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [3:0] sel);
        case (sel)
            4'b1110: return m_r;
            4'b1101: return m_l;
            4'b1100: return m_t;
            4'b1011: return {6'b0, m_st};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] mk_addr(input logic [3:0] sel, input logic rd);
        logic [7:0] a;
        a = 8'($urandom);
        a[6:3] = sel;
        a[2] = rd;
        return a;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Runs one frame of nbits clocks; checks read data and output enable
    task automatic frame(input logic [7:0] a, input logic [7:0] d, input int nbits);
        logic [15:0] word;
        logic [7:0]  got, expd;
        logic [3:0]  sel;
        logic        rd;
        bit          oe_bad;
        word = {a, d};
        sel = a[6:3];
        rd = a[2];
        expd = exp_read(sel);
        got = 8'h00;
        oe_bad = 0;
        csn = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 16) ? word[15-i] : 1'b0;
            wait_clk(HALF);
            if (i >= 8 && i < 16) begin
                got = {got[6:0], sdo};
                if (sdo_oe !== rd) oe_bad = 1;
            end else if (i < 8 && sdo_oe !== 1'b0) begin
                oe_bad = 1;
            end
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        wait_clk(HALF);
        csn = 1'b1;
        wait_clk(10);
        chk("R6 output enable during frame", {7'b0, oe_bad}, 8'h00);
        chk("R6 high impedance with select high", {7'b0, sdo_oe}, 8'h00);
        if (nbits == 16) begin
            if (rd) begin
                chk($sformatf("R1 read data sel %b", sel), got, expd);
                if (sel == 4'b1011) m_st = 2'b00;
            end else begin
                case (sel)
                    4'b1110: begin m_r = d; e_upd_r++; end
                    4'b1101: begin m_l = d; e_upd_l++; end
                    4'b1001: begin m_l = d; m_r = d; e_upd_l++; e_upd_r++; end
                    4'b1100: m_t = d;
                    default: ;
                endcase
            end
        end
        chk("R2 left gain port", g_l, m_l);
        chk("R2 right gain port", g_r, m_r);
        chk("R4 threshold port", thr, m_t);
        chk("R9 left strobe count", 8'(n_upd_l), 8'(e_upd_l));
        chk("R9 right strobe count", 8'(n_upd_r), 8'(e_upd_r));
    endtask

    task automatic pulse_ovl(input logic l, input logic r);
        ovl_l = l;
        ovl_r = r;
        wait_clk(1);
        ovl_l = 1'b0;
        ovl_r = 1'b0;
        m_st = m_st | {l, r};
        wait_clk(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        // R5 reset state at ports and through reads
        chk("R5 left gain reset", g_l, 8'h00);
        chk("R5 right gain reset", g_r, 8'h00);
        chk("R5 threshold reset", thr, 8'hFF);
        chk("R6 idle output enable", {7'b0, sdo_oe}, 8'h00);
        frame(mk_addr(4'b1100, 1), 8'h00, 16);
        frame(mk_addr(4'b1011, 1), 8'h00, 16);
        frame(mk_addr(4'b1101, 1), 8'h00, 16);

        // R2 single-channel writes and readback
        frame(mk_addr(4'b1101, 0), 8'h5A, 16);
        frame(mk_addr(4'b1110, 0), 8'hA7, 16);
        frame(mk_addr(4'b1101, 1), 8'h00, 16);
        frame(mk_addr(4'b1110, 1), 8'h00, 16);
        // R3 alias write, alias reads as zero
        frame(mk_addr(4'b1001, 0), 8'hC3, 16);
        frame(mk_addr(4'b1001, 1), 8'h00, 16);
        frame(mk_addr(4'b1110, 1), 8'h00, 16);
        // R4 threshold
        frame(mk_addr(4'b1100, 0), 8'h40, 16);
        frame(mk_addr(4'b1100, 1), 8'h00, 16);
        // R7 short and long frames discarded
        frame(mk_addr(4'b1101, 0), 8'h11, 10);
        frame(mk_addr(4'b1001, 0), 8'h22, 15);
        frame(mk_addr(4'b1110, 0), 8'h33, 17);
        // R8 sticky status, write ignored, cleared by read
        pulse_ovl(1, 0);
        pulse_ovl(0, 1);
        frame(mk_addr(4'b1011, 0), 8'h00, 16);
        frame(mk_addr(4'b1011, 1), 8'h00, 12);
        frame(mk_addr(4'b1011, 1), 8'h00, 16);
        frame(mk_addr(4'b1011, 1), 8'h00, 16);
        pulse_ovl(1, 0);
        frame(mk_addr(4'b1011, 1), 8'h00, 16);
        // R10 undefined selectors
        frame(mk_addr(4'b0000, 0), 8'h77, 16);
        frame(mk_addr(4'b1111, 0), 8'h77, 16);
        frame(mk_addr(4'b0110, 1), 8'h00, 16);

        // random traffic
        for (int k = 0; k < 200; k++) begin
            logic [3:0] sel;
            int         pick, nb;
            pick = int'($urandom % 7);
            case (pick)
                0: sel = 4'b1110;
                1: sel = 4'b1101;
                2: sel = 4'b1100;
                3: sel = 4'b1011;
                4: sel = 4'b1001;
                default: sel = 4'($urandom);
            endcase
            nb = int'($urandom % 20);
            if (nb == 0)      nb = 1 + int'($urandom % 15);
            else if (nb == 1) nb = 17;
            else              nb = 16;
            if (k % 15 == 7) pulse_ovl(1'($urandom), 1'($urandom));
            frame(mk_addr(sel, 1'($urandom)), 8'($urandom), nb);
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule